// File: doc/BRIEF.md
# Operand Specifier Effective-Address Decoder

This block takes a variable-length memory/register operand specifier, one byte per clock, and works out what the operand refers to. The first byte is the addressing byte. In 32-bit addressing it may be followed by a scaled-index byte. After that come zero, one, two or four displacement bytes, least significant first. The operand either names a general register directly, or it names a memory location. For a memory location the block forms the effective address from a snapshot of the eight general register values and the displacement.

The addressing width is chosen per specifier by the `wide_mode` input. Low selects 16-bit addressing, which uses fixed register pairs. High selects 32-bit addressing, which allows a base register, a scaled index and a full 32-bit displacement. On the clock where the final byte of a specifier is accepted, the block reports the result together with the specifier length in bytes. The byte after that is taken as the first byte of a new specifier. The parameter `NARROW_EN` picks whether the 16-bit address path is built.

Top module: `operand_ea_decoder`

## Requirements
- R1: The first byte of a specifier splits as mode = bits 7:6, spare = bits 5:3 and slot = bits 2:0. `reg_field` equals the spare field whenever `done` is high.
- R2: When mode = 3, the operand is a register. `is_reg` = 1, `reg_num` = slot, `spec_len` = 1, and `done` rises on that same byte.
- R3: In 16-bit addressing with mode = 0, the slot picks the address as follows: 0 = BX+SI, 1 = BX+DI, 2 = BP+SI, 3 = BP+DI, 4 = SI, 5 = DI, 7 = BX. Slot 6 is a direct 16-bit displacement with no register, 3 bytes long. The 16-bit registers are the low halves of register numbers 3 (BX), 5 (BP), 6 (SI) and 7 (DI).
- R4: In 16-bit addressing, mode = 1 adds a sign-extended 8-bit displacement and mode = 2 adds a 16-bit displacement, with the slot-6 term being BP. The sum wraps to 16 bits and bits 31:16 of `eff_addr` are zero. A slot of 4 here never brings in an index byte.
- R5: In 32-bit addressing, mode = 0 with slot = 5 gives a direct 32-bit displacement with no register, 5 bytes long.
- R6: In 32-bit addressing with no index byte, the address is register[slot] plus either a sign-extended 8-bit displacement (mode = 1) or a 32-bit displacement (mode = 2). Register n is `gpr_vals[32n+31:32n]`.
- R7: In 32-bit addressing, an index byte follows exactly when mode != 3 and slot = 4. Its fields are scale = bits 7:6, index = bits 5:3 and base = bits 2:0. The address is reg[base] + (reg[index] << scale), and an index value of 4 contributes nothing.
- R8: An index byte with base = 5 under mode = 0 means no base register plus a 32-bit displacement, for 6 bytes in total. Under mode 1 or 2, base = 5 uses register 5.
- R9: `done` is high only on the clock that accepts the final byte. `spec_len` counts the first byte, the index byte and the displacement bytes. Cycles with `in_valid` low change nothing. The next accepted byte starts a new specifier.
- R10: 32-bit addresses wrap modulo 2^32.
- R11: The addressing width is sampled with the first byte and holds for the whole specifier, whatever `wide_mode` does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A specifier byte is offered this cycle |
| in_byte | input | 8 | Specifier byte |
| wide_mode | input | 1 | 1 = 32-bit addressing, 0 = 16-bit; sampled with the first byte |
| gpr_vals | input | 256 | Eight 32-bit register values, register n at bits 32n+31:32n |
| done | output | 1 | Final byte of a specifier accepted this cycle |
| is_reg | output | 1 | Operand is a register (valid with done) |
| reg_num | output | 3 | Register number for a register operand |
| reg_field | output | 3 | Spare field of the first byte |
| eff_addr | output | 32 | Effective address (valid with done, zero for register operands) |
| spec_len | output | 3 | Specifier length in bytes (valid with done) |

## Verification
The in-RTL assertions check a set of properties on every cycle. A register operand always reports a length of one. Reported lengths stay between one and six. An index-byte specifier is at least two bytes long. A 16-bit address never sets the upper half. The parser goes back to expecting a first byte after `done`, and it does not move while `in_valid` is low. The displacement counter never goes past the byte count it expects. The actual address values are shown only by the bench's scenarios: each 16-bit register pair, the direct-displacement forms, sign extension, scaling, the no-index and no-base index-byte codes, wrap-around in both widths, stalls between bytes, and a change of `wide_mode` in the middle of a specifier.

// File: rtl/ea_dec_pkg.sv
package ea_dec_pkg;

   typedef enum logic [1:0] {
      PH_FIRST = 2'd0,
      PH_INDEX = 2'd1,
      PH_DISP  = 2'd2
   } phase_e;

   localparam logic [1:0] MODE_REG = 2'd3;
   localparam logic [2:0] SLOT_ESC = 3'd4;   // escape to index byte (wide)
   localparam logic [2:0] SLOT_DIR = 3'd5;   // direct / frame-pointer slot
   localparam logic [2:0] SLOT_D16 = 3'd6;   // direct slot in narrow mode
   localparam logic [2:0] IDX_NONE = 3'd4;

   function automatic logic wants_index(input logic wide, input logic [1:0] md,
                                        input logic [2:0] sl);
      return wide && (md != MODE_REG) && (sl == SLOT_ESC);
   endfunction

   // displacement byte count decided by the first byte alone
   function automatic logic [2:0] disp_after_first(input logic wide,
                                                   input logic [1:0] md,
                                                   input logic [2:0] sl);
      logic [2:0] n;
      n = 3'd0;
      unique case (md)
         2'd0: if (wide) n = (sl == SLOT_DIR) ? 3'd4 : 3'd0;
               else      n = (sl == SLOT_D16) ? 3'd2 : 3'd0;
         2'd1: n = 3'd1;
         2'd2: n = wide ? 3'd4 : 3'd2;
         default: n = 3'd0;
      endcase
      return n;
   endfunction

   // displacement byte count once the index byte is known
   function automatic logic [2:0] disp_after_index(input logic [1:0] md,
                                                   input logic [2:0] base);
      logic [2:0] n;
      unique case (md)
         2'd0: n = (base == SLOT_DIR) ? 3'd4 : 3'd0;
         2'd1: n = 3'd1;
         default: n = 3'd4;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/ea_disp_merge.sv
module ea_disp_merge #(
   parameter int REG_W = 32
) (
   input  logic [31:0]      disp_q,
   input  logic [7:0]       new_byte,
   input  logic             ins_en,
   input  logic [1:0]       ins_pos,
   input  logic [2:0]       nbytes,
   output logic [REG_W-1:0] disp_ext
);
   localparam int LANES = 4;

   logic [LANES-1:0][7:0] lane;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = (ins_en && (ins_pos == 2'(g))) ? new_byte : disp_q[8*g +: 8];
   end

   always_comb begin
      unique case (nbytes)
         3'd1:    disp_ext = REG_W'($signed(lane[0]));
         3'd2:    disp_ext = REG_W'({lane[1], lane[0]});
         3'd4:    disp_ext = REG_W'(lane);
         default: disp_ext = '0;
      endcase
   end
endmodule

// File: rtl/ea_addr_wide.sv
module ea_addr_wide #(
   parameter int REG_W = 32,
   parameter int NREG  = 8
) (
   input  logic [NREG-1:0][REG_W-1:0] gpr,
   input  logic [1:0]                 md,
   input  logic [2:0]                 slot,
   input  logic [7:0]                 idx_byte,
   input  logic [REG_W-1:0]           disp,
   output logic [REG_W-1:0]           addr
);
   import ea_dec_pkg::*;

   logic [1:0]       scale;
   logic [2:0]       idx_sel, base_sel;
   logic [REG_W-1:0] base_term, idx_term;

   assign scale    = idx_byte[7:6];
   assign idx_sel  = idx_byte[5:3];
   assign base_sel = idx_byte[2:0];

   always_comb begin
      base_term = '0;
      idx_term  = '0;
      if (slot != SLOT_ESC) begin
         if (!(md == 2'd0 && slot == SLOT_DIR)) base_term = gpr[slot];
      end else begin
         if (!(md == 2'd0 && base_sel == SLOT_DIR)) base_term = gpr[base_sel];
         if (idx_sel != IDX_NONE) idx_term = gpr[idx_sel] << scale;
      end
      addr = base_term + idx_term + disp;
   end
endmodule

// File: rtl/ea_addr_narrow.sv
module ea_addr_narrow #(
   parameter int REG_W = 32,
   parameter int NREG  = 8
) (
   input  logic [NREG-1:0][REG_W-1:0] gpr,
   input  logic [1:0]                 md,
   input  logic [2:0]                 slot,
   input  logic [REG_W-1:0]           disp,
   output logic [REG_W-1:0]           addr
);
   localparam int BX = 3, BP = 5, SI = 6, DI = 7;

   logic [15:0] sum;

   always_comb begin
      unique case (slot)
         3'd0: sum = gpr[BX][15:0] + gpr[SI][15:0];
         3'd1: sum = gpr[BX][15:0] + gpr[DI][15:0];
         3'd2: sum = gpr[BP][15:0] + gpr[SI][15:0];
         3'd3: sum = gpr[BP][15:0] + gpr[DI][15:0];
         3'd4: sum = gpr[SI][15:0];
         3'd5: sum = gpr[DI][15:0];
         3'd6: sum = (md == 2'd0) ? 16'h0000 : gpr[BP][15:0];
         default: sum = gpr[BX][15:0];
      endcase
      addr = REG_W'(16'(sum + disp[15:0]));
   end
endmodule

// File: rtl/operand_ea_decoder.sv
module operand_ea_decoder #(
   parameter int REG_W     = 32,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   input  logic             wide_mode,
   input  logic [8*REG_W-1:0] gpr_vals,
   output logic             done,
   output logic             is_reg,
   output logic [2:0]       reg_num,
   output logic [2:0]       reg_field,
   output logic [REG_W-1:0] eff_addr,
   output logic [2:0]       spec_len
);
   import ea_dec_pkg::*;

   localparam int NREG = 8;

   if (REG_W != 32) begin : g_bad_width
      $error("operand_ea_decoder: REG_W must be 32");
   end

   logic [NREG-1:0][REG_W-1:0] gpr;
   assign gpr = gpr_vals;

   // ---------------- state
   phase_e      phase_q;
   logic        wide_q;
   logic [7:0]  first_q, index_q;
   logic [31:0] disp_q;
   logic [2:0]  dcnt_q, dneed_q;

   // ---------------- current view (stored bytes merged with incoming byte)
   logic        wide_c, has_idx_c, last_c;
   logic [7:0]  first_c, index_c;
   logic [1:0]  md_c;
   logic [2:0]  slot_c, need_c, ndisp_c;

   assign wide_c  = (phase_q == PH_FIRST) ? wide_mode : wide_q;
   assign first_c = (phase_q == PH_FIRST) ? in_byte   : first_q;
   assign index_c = (phase_q == PH_INDEX) ? in_byte   : index_q;
   assign md_c    = first_c[7:6];
   assign slot_c  = first_c[2:0];
   assign has_idx_c = wants_index(wide_c, md_c, slot_c);

   always_comb begin
      unique case (phase_q)
         PH_FIRST: begin
            need_c = has_idx_c ? 3'd0 : disp_after_first(wide_c, md_c, slot_c);
            last_c = !has_idx_c && (need_c == 3'd0);
         end
         PH_INDEX: begin
            need_c = disp_after_index(md_c, in_byte[2:0]);
            last_c = (need_c == 3'd0);
         end
         default: begin
            need_c = dneed_q;
            last_c = (dcnt_q + 3'd1 == dneed_q);
         end
      endcase
   end

   assign ndisp_c = (phase_q == PH_DISP) ? dneed_q : 3'd0;

   // ---------------- sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FIRST;
         wide_q  <= 1'b0;
         first_q <= '0;
         index_q <= '0;
         disp_q  <= '0;
         dcnt_q  <= '0;
         dneed_q <= '0;
      end else if (in_valid) begin
         unique case (phase_q)
            PH_FIRST: begin
               first_q <= in_byte;
               wide_q  <= wide_mode;
               dcnt_q  <= '0;
               dneed_q <= need_c;
               if (has_idx_c)       phase_q <= PH_INDEX;
               else if (!last_c)    phase_q <= PH_DISP;
            end
            PH_INDEX: begin
               index_q <= in_byte;
               dcnt_q  <= '0;
               dneed_q <= need_c;
               phase_q <= last_c ? PH_FIRST : PH_DISP;
            end
            default: begin
               disp_q[8*dcnt_q[1:0] +: 8] <= in_byte;
               dcnt_q <= dcnt_q + 3'd1;
               if (last_c) phase_q <= PH_FIRST;
            end
         endcase
      end
   end

   // ---------------- datapath
   logic [REG_W-1:0] disp_ext, addr_w, addr_n;

   ea_disp_merge #(.REG_W(REG_W)) i_disp (
      .disp_q  (disp_q),
      .new_byte(in_byte),
      .ins_en  (phase_q == PH_DISP),
      .ins_pos (dcnt_q[1:0]),
      .nbytes  (ndisp_c),
      .disp_ext(disp_ext)
   );

   ea_addr_wide #(.REG_W(REG_W), .NREG(NREG)) i_wide (
      .gpr     (gpr),
      .md      (md_c),
      .slot    (slot_c),
      .idx_byte(index_c),
      .disp    (disp_ext),
      .addr    (addr_w)
   );

   if (NARROW_EN) begin : g_narrow
      ea_addr_narrow #(.REG_W(REG_W), .NREG(NREG)) i_narrow (
         .gpr (gpr),
         .md  (md_c),
         .slot(slot_c),
         .disp(disp_ext),
         .addr(addr_n)
      );
   end else begin : g_no_narrow
      assign addr_n = '0;
   end

   assign done      = in_valid && last_c;
   assign is_reg    = (md_c == MODE_REG);
   assign reg_num   = slot_c;
   assign reg_field = first_c[5:3];
   assign eff_addr  = is_reg ? '0 : (wide_c ? addr_w : addr_n);
   assign spec_len  = 3'd1 + {2'b00, has_idx_c} + ndisp_c;

   // ---------------- assertions
   assert_reg_len_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_reg) |-> (spec_len == 3'd1));

   assert_len_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (spec_len >= 3'd1 && spec_len <= 3'd6));

   assert_fresh_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (phase_q == PH_FIRST));

   assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (phase_q == $past(phase_q) && dcnt_q == $past(dcnt_q)));

   assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !is_reg && !wide_c) |-> (eff_addr[REG_W-1:16] == '0));

   assert_index_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && wide_c && md_c != MODE_REG && slot_c == SLOT_ESC) |-> (spec_len >= 3'd2));

   assert_disp_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DISP) |-> (dcnt_q < dneed_q));

   assert_mode_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_FIRST) |=> (wide_q == $past(wide_q)));
endmodule

// File: tb/test_operand_ea_decoder.sv
`timescale 1ns/1ps
module test_operand_ea_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        wide_mode = 1'b0;
   logic [255:0] gpr_vals;
   logic        done, is_reg;
   logic [2:0]  reg_num, reg_field, spec_len;
   logic [31:0] eff_addr;

   int n_checks = 0;
   int n_errs   = 0;
   logic [31:0] gv [8];

   always #2.5 clk = ~clk;

   operand_ea_decoder i_operand_ea_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .wide_mode(wide_mode), .gpr_vals(gpr_vals), .done(done), .is_reg(is_reg),
      .reg_num(reg_num), .reg_field(reg_field), .eff_addr(eff_addr), .spec_len(spec_len)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one specifier; optional idle gap between bytes; optional mode flip after first byte
   task automatic run_spec(input string req, input logic wide, input int n,
                           input logic [7:0] bs [6], input logic exp_reg,
                           input logic [2:0] exp_num, input logic [2:0] exp_field,
                           input logic [31:0] exp_addr, input int gap, input bit flip);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid  = 1'b1;
         in_byte   = bs[i];
         wide_mode = (i == 0) ? wide : (flip ? ~wide : wide);
         #1;
         if (i < n - 1) begin
            check({req, " done low mid-specifier"}, 32'(done), 32'd0);
         end else begin
            check({req, " done"},   32'(done), 32'd1);
            check({req, " len"},    32'(spec_len), 32'(n));
            check({req, " is_reg"}, 32'(is_reg), 32'(exp_reg));
            check({req, " field R1"}, 32'(reg_field), 32'(exp_field));
            if (exp_reg) check({req, " reg_num"}, 32'(reg_num), 32'(exp_num));
            else         check({req, " addr"},    eff_addr, exp_addr);
         end
         for (int k = 0; k < gap && i < n - 1; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'hC0;
            #1;
            check({req, " stall done low"}, 32'(done), 32'd0);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      check("R9 reset done", 32'(done), 32'd0);
   endtask

   task automatic t_register_form();
      run_spec("R2 wide reg", 1'b1, 1, '{8'hDA, 0, 0, 0, 0, 0}, 1'b1, 3'd2, 3'd3, 0, 0, 0);
      run_spec("R2 narrow reg", 1'b0, 1, '{8'hC7, 0, 0, 0, 0, 0}, 1'b1, 3'd7, 3'd0, 0, 0, 0);
   endtask

   task automatic t_narrow_table();
      run_spec("R3 bx+si", 1'b0, 1, '{8'h00, 0, 0, 0, 0, 0}, 1'b0, 0, 3'd0,
               32'((gv[3][15:0] + gv[6][15:0]) & 16'hFFFF), 0, 0);
      run_spec("R3 bp+di", 1'b0, 1, '{8'h0B, 0, 0, 0, 0, 0}, 1'b0, 0, 3'd1,
               32'((gv[5] + gv[7]) & 32'hFFFF), 0, 0);
      run_spec("R3 direct16", 1'b0, 3, '{8'h16, 8'h34, 8'h12, 0, 0, 0}, 1'b0, 0, 3'd2,
               32'h1234, 0, 0);
      run_spec("R4 slot4 no index byte", 1'b0, 1, '{8'h04, 0, 0, 0, 0, 0}, 1'b0, 0, 3'd0,
               32'(gv[6][15:0]), 0, 0);
   endtask

   task automatic t_narrow_disp();
      run_spec("R4 bx+d8 neg", 1'b0, 2, '{8'h7F, 8'hFE, 0, 0, 0, 0}, 1'b0, 0, 3'd7,
               32'((gv[3] - 32'd2) & 32'hFFFF), 0, 0);
      run_spec("R4 bp+si+d16 wrap", 1'b0, 3, '{8'hAA, 8'h00, 8'h40, 0, 0, 0}, 1'b0, 0, 3'd5,
               32'((gv[5] + gv[6] + 32'h4000) & 32'hFFFF), 0, 0);
   endtask

   task automatic t_wide_plain();
      run_spec("R5 direct32", 1'b1, 5, '{8'h0D, 8'h78, 8'h56, 8'h34, 8'h12, 0}, 1'b0, 0, 3'd1,
               32'h12345678, 0, 0);
      run_spec("R6 eax+d8 neg", 1'b1, 2, '{8'h60, 8'h80, 0, 0, 0, 0}, 1'b0, 0, 3'd4,
               gv[0] - 32'd128, 0, 0);
      run_spec("R6 esi+d32", 1'b1, 5, '{8'h9E, 8'h10, 8'h00, 8'h00, 8'h00, 0}, 1'b0, 0, 3'd3,
               gv[6] + 32'h10, 0, 0);
      run_spec("R10 wrap32", 1'b1, 5, '{8'h87, 8'h00, 8'h00, 8'h00, 8'hF0, 0}, 1'b0, 0, 3'd0,
               gv[7] + 32'hF0000000, 0, 0);
   endtask

   task automatic t_index_byte();
      run_spec("R7 ebx+ecx*4", 1'b1, 2, '{8'h04, 8'h8B, 0, 0, 0, 0}, 1'b0, 0, 3'd0,
               gv[3] + (gv[1] << 2), 0, 0);
      run_spec("R7 no index", 1'b1, 2, '{8'h04, 8'hE0, 0, 0, 0, 0}, 1'b0, 0, 3'd0,
               gv[0], 0, 0);
      run_spec("R8 no base d32", 1'b1, 6, '{8'h04, 8'h35, 8'h00, 8'h01, 8'h00, 8'h00},
               1'b0, 0, 3'd0, gv[6] + 32'h100, 0, 0);
      run_spec("R8 base5 mode1", 1'b1, 3, '{8'h44, 8'h25, 8'h04, 0, 0, 0}, 1'b0, 0, 3'd0,
               gv[5] + 32'd4, 0, 0);
   endtask

   task automatic t_stall();
      run_spec("R9 stalled direct32", 1'b1, 5, '{8'h0D, 8'hEF, 8'hBE, 8'hAD, 8'hDE, 0},
               1'b0, 0, 3'd1, 32'hDEADBEEF, 2, 0);
      run_spec("R9 next fresh", 1'b1, 1, '{8'hD9, 0, 0, 0, 0, 0}, 1'b1, 3'd1, 3'd3, 0, 0, 0);
   endtask

   task automatic t_mode_flip();
      run_spec("R11 wide held", 1'b1, 5, '{8'h0D, 8'h44, 8'h33, 8'h22, 8'h11, 0}, 1'b0, 0,
               3'd1, 32'h11223344, 0, 1);
      run_spec("R11 narrow held", 1'b0, 3, '{8'h16, 8'hCD, 8'hAB, 0, 0, 0}, 1'b0, 0, 3'd2,
               32'h0000ABCD, 0, 1);
   endtask

   initial begin
      for (int r = 0; r < 8; r++) gv[r] = 32'h11111111 * (r + 1);
      for (int r = 0; r < 8; r++) gpr_vals[32*r +: 32] = gv[r];
      t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_register_form();
      t_narrow_table();
      t_narrow_disp();
      t_wide_plain();
      t_index_byte();
      t_stall();
      t_mode_flip();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      #100000;
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule